// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a watchdog built around a 12-bit down-counter. A programmable prescaler steps the counter, dividing the core clock by a power of two. Software drives it through a small register bus that has a write enable, a byte address, write data and combinational read data. All commands are 16-bit key codes written to the key register. One key starts the counter. One key refreshes it. One key opens the configuration registers for writing, and any other key closes them again.

The block raises a single-cycle `reset_req` in two cases: when the counter runs out, or when a refresh arrives while the count is outside the permitted window. After the pulse the counter reloads and keeps running. An early-wakeup comparator sets a pending flag and drives `early_irq` when the count drops below a programmable threshold. Each configuration field is applied through a short multi-cycle transfer. A busy flag is visible while that transfer is in flight.

The register bus has no handshake: every write takes effect on the clock edge where `reg_we` is high. Reads return the addressed register in the same cycle.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset the counter is idle and `reset_req` and `early_irq` are low. Prescaler code reads 0, reload and window read 0xFFF, status and early control read 0, and the key register always reads 0.
- R2: Key 0xCCCC at byte offset 0 starts the counter from the reload value R. With no refresh, `reset_req` pulses high for one cycle exactly (R+1)·D cycles after the load edge, where D is the divide ratio. The counter then reloads and repeats with the same period. While the counter is idle, `reset_req` stays low.
- R3: The prescaler field (offset 4, bits 3:0) selects D = 4, 8, 16, 32, 64, 128, 256, 512 or 1024 for codes 0 through 8. Codes 9 through 15 select D = 1024.
- R4: Key 0xAAAA reloads the counter. If the current count c satisfies 2 ≤ c ≤ W, where W is the window value (offset 16, bits 11:0), no reset is raised. Otherwise `reset_req` pulses on the next cycle. A refresh while idle has no effect.
- R5: The early control register (offset 20) holds a threshold T in bits 11:0 and an enable in bit 15. While running and enabled, the flag sets one cycle after the count first becomes less than T. The flag drives `early_irq` and reads as status bit 14.
- R6: Writing 1 to bit 14 of offset 20 clears the flag on the next cycle. Writing 0 there leaves it set. Bit 14 always reads as 0.
- R7: Writes to offsets 4, 8, 16 and the threshold/enable part of offset 20 take effect only while unlocked. Key 0x5555 unlocks. Any other key value, including 0xAAAA and 0xCCCC, locks. Locked writes change nothing.
- R8: An accepted configuration write sets its status busy bit (bit 0 prescaler, bit 1 reload, bit 2 window, bit 3 early control) for exactly 3 cycles. The old value stays readable and in use until the bit clears, and the new value is applied at that point. A write to a field whose busy bit is set is ignored.
- R9: Register byte offsets are: key 0, prescaler 4, reload 8, status 12 (read-only), window 16, early control 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| reset_req | output | 1 | One-cycle reset request |
| early_irq | output | 1 | Early-wakeup pending flag |

## Verification
Each result has a fixed latency:
- Key commands and refreshes act on the write edge. A bad refresh shows `reset_req` on the cycle right after that edge.
- A busy bit is set from the cycle after the write and clears after the third edge, when the new value becomes readable.
- A timeout appears (R+1)·D cycles after the load edge.
- The early flag follows the edge where the count falls below T by one cycle.

The bench drives stimulus at falling edges and samples outputs at falling edges. It counts cycles from a known load edge, so each check lands on the exact cycle predicted. Refreshes are placed at window-edge counts 1, 2, W and W+1, and every prescaler code is swept.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int NUM_CFG = 4;

  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

  localparam logic [2:0] SEL_KEY  = 3'd0;
  localparam logic [2:0] SEL_PRE  = 3'd1;
  localparam logic [2:0] SEL_RLD  = 3'd2;
  localparam logic [2:0] SEL_STAT = 3'd3;
  localparam logic [2:0] SEL_WIN  = 3'd4;
  localparam logic [2:0] SEL_EWC  = 3'd5;
  localparam logic [2:0] SEL_NONE = 3'd7;

  localparam int ACK_BIT  = 14;
  localparam int FLAG_BIT = 14;
  localparam int EWIE_BIT = 15;
endpackage

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
  parameter int W = 12,
  parameter logic [W-1:0] INIT = '0,
  parameter int BUSY_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] q
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [BW-1:0] left;
  logic [W-1:0]  pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      pend <= INIT;
      q    <= INIT;
    end else if (wr && left == '0) begin
      pend <= din;
      left <= BW'(BUSY_CYC);
    end else if (left != '0) begin
      left <= left - BW'(1);
      if (left == BW'(1)) q <= pend;
    end
  end

  assign busy = (left != '0);

  // R8: busy only starts from a write strobe
  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr));
  // R8: applied value moves only at the end of a transfer
  p_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(q));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PS_W = 4,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata,
  output logic [PS_W-1:0]   pre_code,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  win,
  output logic [CNT_W-1:0]  ewit,
  output logic              ewie,
  output logic              start_key,
  output logic              refresh_key,
  output logic              ack
);
  logic [2:0]         sel;
  logic               unlocked;
  logic               cfg_we;
  logic [NUM_CFG-1:0] busy;

  assign sel    = (addr[1:0] == 2'b00) ? addr[ADDR_W-1:2] : SEL_NONE;
  assign cfg_we = we && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (we && sel == SEL_KEY) unlocked <= (wdata == KEY_UNLOCK);
  end

  assign start_key   = we && sel == SEL_KEY && wdata == KEY_START;
  assign refresh_key = we && sel == SEL_KEY && wdata == KEY_REFRESH;
  assign ack         = we && sel == SEL_EWC && wdata[ACK_BIT];

  wdg_cfg_slot #(.W(PS_W), .INIT('0), .BUSY_CYC(BUSY_CYC)) u_pre (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we && sel == SEL_PRE),
    .din(wdata[PS_W-1:0]), .busy(busy[0]), .q(pre_code));

  wdg_cfg_slot #(.W(CNT_W), .INIT({CNT_W{1'b1}}), .BUSY_CYC(BUSY_CYC)) u_rld (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we && sel == SEL_RLD),
    .din(wdata[CNT_W-1:0]), .busy(busy[1]), .q(reload));

  wdg_cfg_slot #(.W(CNT_W), .INIT({CNT_W{1'b1}}), .BUSY_CYC(BUSY_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we && sel == SEL_WIN),
    .din(wdata[CNT_W-1:0]), .busy(busy[2]), .q(win));

  wdg_cfg_slot #(.W(CNT_W + 1), .INIT('0), .BUSY_CYC(BUSY_CYC)) u_ewc (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we && sel == SEL_EWC),
    .din({wdata[EWIE_BIT], wdata[CNT_W-1:0]}), .busy(busy[3]), .q({ewie, ewit}));

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_PRE:  rdata[PS_W-1:0] = pre_code;
      SEL_RLD:  rdata[CNT_W-1:0] = reload;
      SEL_STAT: begin
        rdata[NUM_CFG-1:0] = busy;
        rdata[FLAG_BIT]    = flag;
      end
      SEL_WIN:  rdata[CNT_W-1:0] = win;
      SEL_EWC:  begin
        rdata[CNT_W-1:0] = ewit;
        rdata[EWIE_BIT]  = ewie;
      end
      default:  rdata = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_lock_chk
    // R7: a transfer only begins while the configuration is unlocked
    p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[k]) |-> $past(unlocked));
  end
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int PS_W = 4,
  parameter int DIV_MIN_LOG2 = 2,
  parameter int DIV_MAX_LOG2 = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clear,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  localparam int PC_W = DIV_MAX_LOG2;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] div_m1;

  always_comb begin
    int lg;
    lg = int'(code) + DIV_MIN_LOG2;
    if (lg > DIV_MAX_LOG2) lg = DIV_MAX_LOG2;
    div_m1 = {PC_W{1'b1}} >> (DIV_MAX_LOG2 - lg);
  end

  assign tick = run && (pc >= div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else if (clear || !run || tick) pc <= '0;
    else pc <= pc + PC_W'(1);
  end

  // R3: smallest divide ratio is at least two, so ticks never abut
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int CNT_W = 12,
  parameter int PS_W = 4,
  parameter int DIV_MIN_LOG2 = 2,
  parameter int DIV_MAX_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PS_W-1:0]  pre_code,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] win,
  input  logic [CNT_W-1:0] ewit,
  input  logic             ewie,
  input  logic             start_key,
  input  logic             refresh_key,
  input  logic             ack,
  output logic             rst_req,
  output logic             irq_flag
);
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             in_win, timeout, bad_ref, load;
  logic             hit, hit_q;

  assign in_win  = (cnt <= win) && (cnt >= CNT_W'(2));
  assign timeout = running && tick && (cnt == '0);
  assign bad_ref = running && refresh_key && !in_win;
  assign load    = (start_key && !running) || (running && refresh_key) || timeout;
  assign hit     = running && ewie && (cnt < ewit);

  wdg_prescale #(.PS_W(PS_W), .DIV_MIN_LOG2(DIV_MIN_LOG2),
                 .DIV_MAX_LOG2(DIV_MAX_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .clear(load),
    .code(pre_code), .tick(tick));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cnt      <= '0;
      rst_req  <= 1'b0;
      hit_q    <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (start_key) running <= 1'b1;
      if (load) cnt <= reload;
      else if (tick) cnt <= cnt - CNT_W'(1);
      rst_req <= timeout || bad_ref;
      hit_q   <= hit;
      if (hit && !hit_q) irq_flag <= 1'b1;
      else if (ack) irq_flag <= 1'b0;
    end
  end

  // R2: nothing is requested while the counter is idle
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !rst_req);
  // R2: every request coincides with a fresh reload
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == $past(reload));
  // R4: refresh above the window or at the bottom must request reset
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && refresh_key && (cnt > win || cnt < CNT_W'(2))) |=> rst_req);
  // R5: flag rises only with the enable and a count under the threshold
  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(ewie) && ($past(cnt) < $past(ewit))));
  // R6: the flag holds until acknowledged
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && irq_flag) |=> irq_flag);
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PS_W = 4,
  parameter int BUSY_CYC = 3,
  parameter int DIV_MIN_LOG2 = 2,
  parameter int DIV_MAX_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reset_req,
  output logic              early_irq
);
  logic [PS_W-1:0]  pre_code;
  logic [CNT_W-1:0] reload, win, ewit;
  logic             ewie, start_key, refresh_key, ack;

  wdg_regs #(.CNT_W(CNT_W), .PS_W(PS_W), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flag(early_irq), .rdata(reg_rdata), .pre_code(pre_code), .reload(reload),
    .win(win), .ewit(ewit), .ewie(ewie), .start_key(start_key),
    .refresh_key(refresh_key), .ack(ack));

  wdg_core #(.CNT_W(CNT_W), .PS_W(PS_W), .DIV_MIN_LOG2(DIV_MIN_LOG2),
             .DIV_MAX_LOG2(DIV_MAX_LOG2)) u_core (
    .clk(clk), .rst_n(rst_n), .pre_code(pre_code), .reload(reload), .win(win),
    .ewit(ewit), .ewie(ewie), .start_key(start_key), .refresh_key(refresh_key),
    .ack(ack), .rst_req(reset_req), .irq_flag(early_irq));
endmodule

// File: tb/sim_keyed_window_wdt.sv
module sim_keyed_window_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        reset_req, early_irq;
  int total = 0;
  int bad = 0;

  localparam logic [4:0] A_KEY = 5'd0, A_PRE = 5'd4, A_RLD = 5'd8,
                         A_STAT = 5'd12, A_WIN = 5'd16, A_EWC = 5'd20;

  always #5 clk = ~clk;

  keyed_window_wdt u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .reset_req(reset_req), .early_irq(early_irq));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // caller sits at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reset_req && n < 6000);
  endtask

  initial begin
    int v, n, hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R9 offsets
    chk("R1 reset_req", int'(reset_req), 0);
    chk("R1 early_irq", int'(early_irq), 0);
    rd(A_PRE, v);  chk("R1 prescaler", v, 0);
    rd(A_RLD, v);  chk("R1 reload", v, 4095);
    rd(A_WIN, v);  chk("R1 window", v, 4095);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_EWC, v);  chk("R1 early ctrl", v, 0);
    @(negedge clk);

    // R8 busy and delayed apply; R9 reload offset
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd3);
    rd(A_STAT, v); chk("R8 busy set", v, 2);
    rd(A_RLD, v);  chk("R8 old value while busy", v, 4095);
    wr(A_RLD, 16'd7);
    @(negedge clk);
    rd(A_STAT, v); chk("R8 busy third cycle", v, 2);
    @(negedge clk);
    rd(A_STAT, v); chk("R8 busy cleared", v, 0);
    rd(A_RLD, v);  chk("R8 applied, busy write ignored", v, 3);
    @(negedge clk);

    // R7 relock by other key; R4 idle refresh ignored; R1 key reads 0
    wr(A_KEY, 16'hAAAA);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      if (reset_req) hits++;
      @(negedge clk);
    end
    chk("R4 idle refresh no reset", hits, 0);
    wr(A_RLD, 16'd9);
    wr(A_PRE, 16'd5);
    repeat (4) @(negedge clk);
    rd(A_RLD, v);  chk("R7 locked reload unchanged", v, 3);
    rd(A_PRE, v);  chk("R7 locked prescaler unchanged", v, 0);
    rd(A_STAT, v); chk("R7 no busy on locked write", v, 0);
    rd(A_KEY, v);  chk("R1 key reads zero", v, 0);
    @(negedge clk);

    // R2 start and timeout period, D=4, R=3
    wr(A_KEY, 16'hCCCC);
    wait_pulse(n); chk("R2 first timeout", n, 16);
    @(negedge clk);
    chk("R2 single-cycle pulse", int'(reset_req), 0);
    wait_pulse(n); chk("R2 repeat period", n, 15);

    // R3 prescaler sweep over every code
    for (int c = 0; c < 16; c++) begin
      int lg, expn;
      wr(A_KEY, 16'h5555);
      wr(A_PRE, 16'(c));
      repeat (4) @(negedge clk);
      rd(A_PRE, v); chk("R3 code readback", v, c);
      @(negedge clk);
      lg = (c + 2 > 10) ? 10 : c + 2;
      expn = 4 * (1 << lg);
      wait_pulse(n);
      wait_pulse(n);
      chk($sformatf("R3 period code %0d", c), n, expn);
    end

    // R4 window checks, D=4, R=20, W=10
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd20);
    wr(A_WIN, 16'd10);
    wr(A_PRE, 16'd0);
    repeat (4) @(negedge clk);
    wr(A_KEY, 16'h0000);
    wr(A_KEY, 16'hAAAA);
    wr(A_KEY, 16'hAAAA);
    chk("R4 early refresh count 20", int'(reset_req), 1);
    repeat (41) @(negedge clk);
    wr(A_KEY, 16'hAAAA);
    chk("R4 refresh at count W", int'(reset_req), 0);
    repeat (37) @(negedge clk);
    wr(A_KEY, 16'hAAAA);
    chk("R4 refresh at count W+1", int'(reset_req), 1);
    repeat (73) @(negedge clk);
    wr(A_KEY, 16'hAAAA);
    chk("R4 refresh at count 2", int'(reset_req), 0);
    repeat (77) @(negedge clk);
    wr(A_KEY, 16'hAAAA);
    chk("R4 refresh at count 1", int'(reset_req), 1);
    repeat (61) @(negedge clk);
    wr(A_KEY, 16'hAAAA);
    chk("R4 refresh at count 5", int'(reset_req), 0);
    wait_pulse(n); chk("R2 timeout after good refresh", n, 84);

    // R5/R6 early wakeup, T=8
    wr(A_KEY, 16'h5555);
    wr(A_EWC, 16'h8008);
    repeat (4) @(negedge clk);
    wr(A_KEY, 16'h0000);
    wait_pulse(n);
    wr(A_EWC, 16'h4000);
    repeat (51) @(negedge clk);
    chk("R5 flag low at count 8", int'(early_irq), 0);
    @(negedge clk);
    chk("R5 flag after count 7", int'(early_irq), 1);
    rd(A_STAT, v); chk("R5 status bit 14", v, 16'h4000);
    wr(A_EWC, 16'h0000);
    chk("R6 write 0 keeps flag", int'(early_irq), 1);
    wr(A_EWC, 16'h4000);
    chk("R6 ack clears flag", int'(early_irq), 0);
    rd(A_EWC, v); chk("R6 ack bit reads 0", v, 16'h8008);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule